// File: doc/BRIEF.md
# Store-to-Load Forwarding Checker

This block decides, for one load at a time, whether an older store still held in the store queue can supply the load's bytes. The load is given as a byte address, a size in bytes, its load-queue slot, its age tag and the store-queue slot it was allocated behind. A small state machine then walks the store queue one entry per cycle, from the youngest older store toward the oldest one not yet written back. The first entry whose byte range touches the load decides the outcome.

There are three outcomes. If the store's bytes fully cover the load, the block returns the load's bytes taken from the store data at the correct byte offset. If the ranges only partly overlap, the block reports a stall, because the load cannot be served until that store drains. It also keeps a record of the oldest load stalled this way and the tag of the store it waits on. If no entry touches the load, the result tells the caller to read memory. The store-queue contents are presented as flat vectors by the queue owner and must stay stable while a scan is running. Memory access and instruction replay belong to the caller.

Top module: `sfwd_check`

## Requirements
- R1: While `rst_n` is low at a clock edge, after that edge `res_valid` is 0, `req_ready` is 1 and `stall_active` is 0.
- R2: Starting from the load's store slot S, the scan examines entries S-1, S-2, … and wraps from slot 0 to slot SQ_DEPTH-1. It stops with the memory result when its pointer equals the write-back slot W, so slot W is the last entry examined. If S equals W, no entry is examined.
- R3: An entry whose size field is 0, or whose uncacheable bit is set, never matches and the scan moves past it.
- R4: If load start ≥ store start and load end ≤ store end (end = address + size), the result kind is forward (2'b01). `res_data` byte k equals store data byte (load address − store address + k) for k < load size, and all bytes at or above the load size are zero.
- R5: If the byte ranges intersect but the store does not contain the load, the result kind is stall (2'b10) and `res_data` is zero.
- R6: The first matching entry in scan order (youngest first) decides the result. Older entries cannot change it.
- R7: If no entry matches before the scan stops, the result kind is memory (2'b00) and `res_data` is zero.
- R8: One entry is examined per clock cycle. `res_valid` rises for one cycle, j edges after the accepting edge when the j-th examined entry decides, or m+1 edges after it when none of the m examined entries match. `req_ready` is low from the edge after acceptance until the result, and requests raised during a scan are ignored and produce no result.
- R9: A stall result leaves `stall_active` at 1, with `stall_st_seq`, `stall_ld_idx` and `stall_ld_seq` holding the store's tag, the load's slot and the load's tag, if the record was empty.
- R10: A new stall replaces an existing record only when the new load's tag is numerically smaller (older, unsigned compare). Otherwise the record is unchanged.
- R11: `stall_clr` high at a clock edge empties the record (`stall_active` 0) and takes priority over a stall decided at that edge.
- R12: `res_st_idx` gives the deciding store slot for forward and stall results and is 0 for memory results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Load check request |
| req_ready | output | 1 | High while idle; a request is accepted when both are high |
| req_addr | input | ADDR_W | Load byte address |
| req_size | input | SZW | Load size in bytes, 1..DATA_BYTES |
| req_ld_idx | input | LIW | Load-queue slot of the load |
| req_ld_seq | input | SEQ_W | Age tag of the load (smaller is older) |
| req_sq_idx | input | QIW | Store slot the load was allocated behind |
| wb_idx | input | QIW | Write-back slot, sampled at acceptance |
| sq_addr | input | SQ_DEPTH*ADDR_W | Store addresses, slot i at bits i*ADDR_W |
| sq_size | input | SQ_DEPTH*SZW | Store sizes, 0 means no data yet |
| sq_data | input | SQ_DEPTH*DATA_BYTES*8 | Store data, byte 0 at the store address |
| sq_seq | input | SQ_DEPTH*SEQ_W | Store age tags |
| sq_nc | input | SQ_DEPTH | Store uncacheable flags |
| res_valid | output | 1 | One-cycle result strobe |
| res_kind | output | 2 | 00 memory, 01 forward, 10 stall |
| res_data | output | DATA_BYTES*8 | Forwarded bytes, right-aligned |
| res_st_idx | output | QIW | Deciding store slot |
| stall_clr | input | 1 | Empty the stall record |
| stall_active | output | 1 | Stall record holds a load |
| stall_st_seq | output | SEQ_W | Tag of the store the recorded load waits on |
| stall_ld_idx | output | LIW | Slot of the recorded load |
| stall_ld_seq | output | SEQ_W | Tag of the recorded load |

## Verification
The in-RTL properties watch, on every cycle, the output shapes that hold for any input: memory and stall results carry zero data, memory results report slot 0, forwarded data is zero above the load size, a stall result leaves the record active, the record only moves to older loads, clearing wins, and an accepted request drops the ready line. Only the bench scenarios can show that the scan visits the right slots in the right order, wraps and stops at the write-back slot, skips empty and uncacheable entries, and lets the youngest match win. The same holds for picking the correct byte offset and for timing each result to the cycle the deciding entry is reached.

// File: rtl/sfwd_pkg.sv
// Shared types for the store-to-load forwarding checker.
package sfwd_pkg;

    // Result classification, value visible on res_kind.
    typedef enum logic [1:0] {
        FWD_NONE  = 2'b00,
        FWD_HIT   = 2'b01,
        FWD_STALL = 2'b10
    } fwd_kind_e;

    // Scan controller state.
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } scan_state_e;

endpackage

// File: rtl/sfwd_overlap.sv
// Byte-range overlap classifier for one store entry against one load.
// Ranges are half-open [addr, addr+size); ends are computed one bit wider
// than the address so no range wraps. Skipped entries never match.
module sfwd_overlap #(
    parameter int AW  = 16,
    parameter int SZW = 4
) (
    input  logic [AW-1:0]  ld_addr,
    input  logic [SZW-1:0] ld_size,
    input  logic [AW-1:0]  st_addr,
    input  logic [SZW-1:0] st_size,
    input  logic           st_nc,
    output logic           hit_full,
    output logic           hit_part
);
    logic [AW:0] ld_lo, ld_hi, st_lo, st_hi;
    logic        skip, contain, touch;

    // Range ends, widened by one bit.
    always_comb begin
        ld_lo = {1'b0, ld_addr};
        st_lo = {1'b0, st_addr};
        ld_hi = ld_lo + {{(AW+1-SZW){1'b0}}, ld_size};
        st_hi = st_lo + {{(AW+1-SZW){1'b0}}, st_size};
    end

    // Classification: containment, intersection, skip rule.
    always_comb begin
        skip     = (st_size == '0) || st_nc;
        contain  = (ld_lo >= st_lo) && (ld_hi <= st_hi);
        touch    = (ld_lo < st_hi) && (ld_hi > st_lo);
        hit_full = !skip && contain;
        hit_part = !skip && touch && !contain;
    end
endmodule

// File: rtl/sfwd_extract.sv
// Byte extractor: shifts store data down by a byte offset and keeps only
// the low ld_size bytes, zero-filling the rest. Assumes DB is a power of
// two of at least 2 and offset+ld_size <= DB when the result is used.
module sfwd_extract #(
    parameter int DB  = 8,
    parameter int SZW = 4,
    localparam int OFW = $clog2(DB),
    localparam int DW  = DB * 8
) (
    input  logic [DW-1:0]  st_data,
    input  logic [OFW-1:0] offset,
    input  logic [SZW-1:0] ld_size,
    output logic [DW-1:0]  ld_data
);
    logic [DW-1:0] shifted;

    // Align the requested bytes to bit 0.
    assign shifted = st_data >> {offset, 3'b000};

    // Per-byte keep or zero, by byte position against the load size.
    for (genvar b = 0; b < DB; b++) begin : g_byte
        assign ld_data[b*8 +: 8] = (SZW'(b) < ld_size) ? shifted[b*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/sfwd_stall_track.sv
// Stall record: keeps the oldest load that hit a partial overlap and the
// tag of the store it waits on. Age tags compare as plain unsigned values.
// A clear at the same edge as a set wins.
module sfwd_stall_track #(
    parameter int SW  = 16,
    parameter int LIW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           set,
    input  logic [SW-1:0]  set_st_seq,
    input  logic [LIW-1:0] set_ld_idx,
    input  logic [SW-1:0]  set_ld_seq,
    input  logic           clr,
    output logic           active,
    output logic [SW-1:0]  st_seq,
    output logic [LIW-1:0] ld_idx,
    output logic [SW-1:0]  ld_seq
);
    logic take;

    // A new stall is taken when the record is empty or the load is older.
    assign take = set && (!active || (set_ld_seq < ld_seq));

    // Record update with clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            st_seq <= '0;
            ld_idx <= '0;
            ld_seq <= '0;
        end else if (clr) begin
            active <= 1'b0;
        end else if (take) begin
            active <= 1'b1;
            st_seq <= set_st_seq;
            ld_idx <= set_ld_idx;
            ld_seq <= set_ld_seq;
        end
    end

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> !active); // R11

    AST_OLDER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !clr) |=> (active && ld_seq <= $past(ld_seq))); // R10
endmodule

// File: rtl/sfwd_check.sv
// Store-to-load forwarding checker. Accepts one load, scans older store
// entries one per cycle from the youngest down to the write-back slot, and
// reports forward / stall / memory with a registered one-cycle strobe.
// Assumes the store-queue vectors stay stable during a scan, load size is
// 1..DATA_BYTES, and DATA_BYTES is a power of two of at least 2.
module sfwd_check
    import sfwd_pkg::*;
#(
    parameter int SQ_DEPTH   = 8,
    parameter int LQ_DEPTH   = 8,
    parameter int ADDR_W     = 16,
    parameter int DATA_BYTES = 8,
    parameter int SEQ_W      = 16,
    localparam int QIW = $clog2(SQ_DEPTH),
    localparam int LIW = $clog2(LQ_DEPTH),
    localparam int SZW = $clog2(DATA_BYTES + 1),
    localparam int DW  = DATA_BYTES * 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [SZW-1:0]           req_size,
    input  logic [LIW-1:0]           req_ld_idx,
    input  logic [SEQ_W-1:0]         req_ld_seq,
    input  logic [QIW-1:0]           req_sq_idx,
    input  logic [QIW-1:0]           wb_idx,
    input  logic [SQ_DEPTH*ADDR_W-1:0] sq_addr,
    input  logic [SQ_DEPTH*SZW-1:0]  sq_size,
    input  logic [SQ_DEPTH*DW-1:0]   sq_data,
    input  logic [SQ_DEPTH*SEQ_W-1:0] sq_seq,
    input  logic [SQ_DEPTH-1:0]      sq_nc,
    output logic                     res_valid,
    output logic [1:0]               res_kind,
    output logic [DW-1:0]            res_data,
    output logic [QIW-1:0]           res_st_idx,
    input  logic                     stall_clr,
    output logic                     stall_active,
    output logic [SEQ_W-1:0]         stall_st_seq,
    output logic [LIW-1:0]           stall_ld_idx,
    output logic [SEQ_W-1:0]         stall_ld_seq
);
    localparam int OFW = $clog2(DATA_BYTES);
    localparam logic [QIW-1:0] TOP_IDX = QIW'(SQ_DEPTH - 1);
    localparam logic [SZW-1:0] DB_SZ   = SZW'(DATA_BYTES);

    scan_state_e       state;
    logic [QIW-1:0]    cur, wb_q, e_idx;
    logic [ADDR_W-1:0] ld_addr_q;
    logic [SZW-1:0]    ld_size_q;
    logic [LIW-1:0]    ld_idx_q;
    logic [SEQ_W-1:0]  ld_seq_q;

    logic [ADDR_W-1:0] e_addr;
    logic [SZW-1:0]    e_size;
    logic [DW-1:0]     e_data;
    logic [SEQ_W-1:0]  e_seq;
    logic              e_nc;
    logic              hit_full, hit_part, at_end, stall_set;
    logic [OFW-1:0]    offset;
    logic [DW-1:0]     fwd_data;

    // Next entry to examine: one slot older, wrapping below zero.
    assign e_idx = (cur == '0) ? TOP_IDX : cur - 1'b1;

    // Field selection for the entry under examination.
    always_comb begin
        e_addr = sq_addr[int'(e_idx)*ADDR_W +: ADDR_W];
        e_size = sq_size[int'(e_idx)*SZW +: SZW];
        e_data = sq_data[int'(e_idx)*DW +: DW];
        e_seq  = sq_seq[int'(e_idx)*SEQ_W +: SEQ_W];
        e_nc   = sq_nc[e_idx];
    end

    // Byte offset of the load within the store, modulo the data width.
    assign offset = ld_addr_q[OFW-1:0] - e_addr[OFW-1:0];

    sfwd_overlap #(.AW(ADDR_W), .SZW(SZW)) u_overlap (
        .ld_addr  (ld_addr_q),
        .ld_size  (ld_size_q),
        .st_addr  (e_addr),
        .st_size  (e_size),
        .st_nc    (e_nc),
        .hit_full (hit_full),
        .hit_part (hit_part)
    );

    sfwd_extract #(.DB(DATA_BYTES), .SZW(SZW)) u_extract (
        .st_data (e_data),
        .offset  (offset),
        .ld_size (ld_size_q),
        .ld_data (fwd_data)
    );

    // Scan termination and stall decision for this cycle.
    assign at_end    = (cur == wb_q);
    assign stall_set = (state == ST_SCAN) && !at_end && !hit_full && hit_part;
    assign req_ready = (state == ST_IDLE);

    // Scan controller and result register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            cur        <= '0;
            wb_q       <= '0;
            ld_addr_q  <= '0;
            ld_size_q  <= '0;
            ld_idx_q   <= '0;
            ld_seq_q   <= '0;
            res_valid  <= 1'b0;
            res_kind   <= FWD_NONE;
            res_data   <= '0;
            res_st_idx <= '0;
        end else begin
            res_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        state     <= ST_SCAN;
                        cur       <= req_sq_idx;
                        wb_q      <= wb_idx;
                        ld_addr_q <= req_addr;
                        ld_size_q <= req_size;
                        ld_idx_q  <= req_ld_idx;
                        ld_seq_q  <= req_ld_seq;
                    end
                end
                ST_SCAN: begin
                    if (at_end) begin
                        state      <= ST_IDLE;
                        res_valid  <= 1'b1;
                        res_kind   <= FWD_NONE;
                        res_data   <= '0;
                        res_st_idx <= '0;
                    end else if (hit_full) begin
                        state      <= ST_IDLE;
                        res_valid  <= 1'b1;
                        res_kind   <= FWD_HIT;
                        res_data   <= fwd_data;
                        res_st_idx <= e_idx;
                    end else if (hit_part) begin
                        state      <= ST_IDLE;
                        res_valid  <= 1'b1;
                        res_kind   <= FWD_STALL;
                        res_data   <= '0;
                        res_st_idx <= e_idx;
                    end else begin
                        cur <= e_idx;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    sfwd_stall_track #(.SW(SEQ_W), .LIW(LIW)) u_stall (
        .clk        (clk),
        .rst_n      (rst_n),
        .set        (stall_set),
        .set_st_seq (e_seq),
        .set_ld_idx (ld_idx_q),
        .set_ld_seq (ld_seq_q),
        .clr        (stall_clr),
        .active     (stall_active),
        .st_seq     (stall_st_seq),
        .ld_idx     (stall_ld_idx),
        .ld_seq     (stall_ld_seq)
    );

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R8

    AST_NONE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind == FWD_NONE) |-> (res_data == '0)); // R7

    AST_STALL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind == FWD_STALL) |-> (res_data == '0)); // R5

    AST_STALL_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind == FWD_STALL) |-> stall_active); // R9

    AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind == FWD_HIT && ld_size_q < DB_SZ)
            |-> ((res_data >> {ld_size_q, 3'b000}) == '0)); // R4

    AST_NONE_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_kind == FWD_NONE) |-> (res_st_idx == '0)); // R12
endmodule

// File: tb/sfwd_check_tb.sv
// Scoreboard bench: the driver computes the expected result from the
// requirements and queues it; the monitor compares each strobe.
module sfwd_check_tb;
    localparam int N   = 8;
    localparam int AW  = 16;
    localparam int DB  = 8;
    localparam int SZW = 4;
    localparam int SW  = 16;
    localparam int LIW = 3;
    localparam int QIW = 3;
    localparam int DW  = DB * 8;

    typedef struct {
        logic [1:0]    kind;
        logic [DW-1:0] data;
        logic [QIW-1:0] idx;
        int            lat;
        string         tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic [AW-1:0]  req_addr = '0;
    logic [SZW-1:0] req_size = '0;
    logic [LIW-1:0] req_ld_idx = '0;
    logic [SW-1:0]  req_ld_seq = '0;
    logic [QIW-1:0] req_sq_idx = '0;
    logic [QIW-1:0] wb_idx = '0;
    logic [N*AW-1:0]  sq_addr = '0;
    logic [N*SZW-1:0] sq_size = '0;
    logic [N*DW-1:0]  sq_data = '0;
    logic [N*SW-1:0]  sq_seq = '0;
    logic [N-1:0]     sq_nc = '0;
    logic res_valid;
    logic [1:0] res_kind;
    logic [DW-1:0] res_data;
    logic [QIW-1:0] res_st_idx;
    logic stall_clr = 1'b0;
    logic stall_active;
    logic [SW-1:0] stall_st_seq;
    logic [LIW-1:0] stall_ld_idx;
    logic [SW-1:0] stall_ld_seq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int acc_cyc = 0;
    exp_t exp_q[$];

    // Bench copy of the store queue and of the stall record.
    int            m_addr[N];
    int            m_size[N];
    logic [DW-1:0] m_data[N];
    int            m_seq[N];
    bit            m_nc[N];
    bit            m_act = 0;
    int            m_st_seq = 0, m_ld_idx = 0, m_ld_seq = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc++;

    sfwd_check u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_ld_idx(req_ld_idx),
        .req_ld_seq(req_ld_seq), .req_sq_idx(req_sq_idx), .wb_idx(wb_idx),
        .sq_addr(sq_addr), .sq_size(sq_size), .sq_data(sq_data), .sq_seq(sq_seq),
        .sq_nc(sq_nc), .res_valid(res_valid), .res_kind(res_kind),
        .res_data(res_data), .res_st_idx(res_st_idx), .stall_clr(stall_clr),
        .stall_active(stall_active), .stall_st_seq(stall_st_seq),
        .stall_ld_idx(stall_ld_idx), .stall_ld_seq(stall_ld_seq)
    );

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic set_entry(input int i, input int a, input int s,
                             input logic [DW-1:0] d, input int sq, input bit nc);
        m_addr[i] = a; m_size[i] = s; m_data[i] = d; m_seq[i] = sq; m_nc[i] = nc;
        sq_addr[i*AW +: AW]  = AW'(a);
        sq_size[i*SZW +: SZW] = SZW'(s);
        sq_data[i*DW +: DW]  = d;
        sq_seq[i*SW +: SW]   = SW'(sq);
        sq_nc[i]             = nc;
    endtask

    task automatic clear_all();
        for (int i = 0; i < N; i++) set_entry(i, 0, 0, '0, 100 + i, 0);
    endtask

    // Monitor: compare each result strobe with the queued expectation.
    always @(negedge clk) begin
        if (rst_n && res_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R8", "unexpected result", DW'(res_kind), '0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(res_kind == e.kind, e.tag, "kind", DW'(res_kind), DW'(e.kind));
                chk(res_data == e.data, e.tag, "data", res_data, e.data);
                chk(res_st_idx == e.idx, "R12", "store slot", DW'(res_st_idx), DW'(e.idx));
                chk((cyc - acc_cyc) == e.lat, "R8", "latency", DW'(cyc - acc_cyc), DW'(e.lat));
            end
        end
    end

    task automatic check_stall(input string tag);
        chk(stall_active == m_act, tag, "stall_active", DW'(stall_active), DW'(m_act));
        if (m_act) begin
            chk(stall_st_seq == SW'(m_st_seq), tag, "stall store tag", DW'(stall_st_seq), DW'(m_st_seq));
            chk(stall_ld_idx == LIW'(m_ld_idx), tag, "stall load slot", DW'(stall_ld_idx), DW'(m_ld_idx));
            chk(stall_ld_seq == SW'(m_ld_seq), tag, "stall load tag", DW'(stall_ld_seq), DW'(m_ld_seq));
        end
    endtask

    // Driver: model the scan, queue the expectation, issue the request.
    task automatic run_load(input int a, input int s, input int li, input int ls,
                            input int sqi, input int wbi, input string tag, input bit poke);
        exp_t e;
        int cur = sqi;
        bit done = 0;
        e.kind = 2'b00; e.data = '0; e.idx = '0; e.lat = 0; e.tag = tag;
        while (!done) begin
            e.lat++;
            if (cur == wbi) begin
                done = 1;
            end else begin
                int x = (cur == 0) ? N - 1 : cur - 1;
                if (m_size[x] != 0 && !m_nc[x]) begin
                    bit full = (a >= m_addr[x]) && (a + s <= m_addr[x] + m_size[x]);
                    bit tch  = (a < m_addr[x] + m_size[x]) && (a + s > m_addr[x]);
                    if (full) begin
                        e.kind = 2'b01; e.idx = QIW'(x); done = 1;
                        for (int b = 0; b < s; b++)
                            e.data[b*8 +: 8] = m_data[x][(a - m_addr[x] + b)*8 +: 8];
                    end else if (tch) begin
                        e.kind = 2'b10; e.idx = QIW'(x); done = 1;
                        if (!m_act || ls < m_ld_seq) begin
                            m_act = 1; m_st_seq = m_seq[x]; m_ld_idx = li; m_ld_seq = ls;
                        end
                    end
                end
                cur = x;
            end
        end
        exp_q.push_back(e);
        @(negedge clk);
        req_addr = AW'(a); req_size = SZW'(s); req_ld_idx = LIW'(li);
        req_ld_seq = SW'(ls); req_sq_idx = QIW'(sqi); wb_idx = QIW'(wbi);
        req_valid = 1'b1;
        @(negedge clk);
        acc_cyc = cyc;
        req_valid = 1'b0;
        if (poke) begin
            req_addr = AW'(a + 1); req_sq_idx = QIW'(0); req_valid = 1'b1;
            @(negedge clk);
            @(negedge clk);
            req_valid = 1'b0;
        end
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
        check_stall("R9");
    endtask

    task automatic pulse_clr();
        @(negedge clk); stall_clr = 1'b1;
        @(negedge clk); stall_clr = 1'b0;
        m_act = 0;
    endtask

    initial begin
        clear_all();
        repeat (3) @(negedge clk);
        chk(res_valid == 1'b0, "R1", "res_valid in reset", DW'(res_valid), '0);
        chk(req_ready == 1'b1, "R1", "req_ready in reset", DW'(req_ready), 1);
        chk(stall_active == 1'b0, "R1", "stall_active in reset", DW'(stall_active), '0);
        rst_n = 1'b1;
        @(negedge clk);

        // R7 R3: empty entries only, memory after 6 cycles.
        run_load(16'h0040, 4, 1, 50, 5, 0, "R7", 0);
        // R4: forward two bytes at offset 2.
        set_entry(3, 16'h0100, 8, 64'h8877_6655_4433_2211, 103, 0);
        run_load(16'h0102, 2, 1, 51, 5, 0, "R4", 0);
        // R4: full eight bytes, offset 0.
        run_load(16'h0100, 8, 1, 52, 5, 0, "R4", 0);
        // R6 R5 R9: younger partial in slot 4 beats older full in slot 3.
        set_entry(4, 16'h0104, 4, 64'h0000_0000_DDCC_BBAA, 104, 0);
        run_load(16'h0102, 4, 2, 60, 5, 0, "R5", 0);
        // R10: younger stalled load leaves the record alone.
        run_load(16'h0102, 4, 6, 70, 5, 0, "R10", 0);
        check_stall("R10");
        // R10: older stalled load replaces it.
        run_load(16'h0102, 4, 5, 40, 5, 0, "R10", 0);
        check_stall("R10");
        // R11: clear empties the record.
        pulse_clr();
        @(negedge clk);
        chk(stall_active == 1'b0, "R11", "after clear", DW'(stall_active), '0);
        // R6: younger full in slot 4, older partial in slot 3.
        set_entry(4, 16'h0100, 8, 64'h0807_0605_0403_0201, 104, 0);
        set_entry(3, 16'h0102, 2, 64'h0000_0000_0000_EEFF, 103, 0);
        run_load(16'h0101, 2, 0, 80, 5, 0, "R6", 0);
        // R3: uncacheable younger entry skipped, older one forwards.
        set_entry(4, 16'h0100, 8, 64'h0807_0605_0403_0201, 104, 1);
        set_entry(3, 16'h0100, 4, 64'h0000_0000_7766_5544, 103, 0);
        run_load(16'h0101, 3, 0, 81, 5, 0, "R3", 0);
        // R3: size-zero entry skipped too, memory result.
        set_entry(3, 16'h0100, 0, 64'h0000_0000_7766_5544, 103, 0);
        run_load(16'h0101, 3, 0, 82, 5, 0, "R3", 0);

        // R2: wrap from slot 0 to slot 7.
        clear_all();
        set_entry(7, 16'h0200, 4, 64'h0000_0000_CAFE_BEEF, 107, 0);
        run_load(16'h0202, 2, 3, 90, 1, 6, "R2", 0);
        // R2: slot 5 lies past the write-back slot and is never examined.
        set_entry(7, 16'h0000, 0, '0, 107, 0);
        set_entry(5, 16'h0200, 4, 64'h0000_0000_CAFE_BEEF, 105, 0);
        run_load(16'h0202, 2, 3, 91, 1, 6, "R2", 0);
        // R2: start equals write-back slot, no entry examined.
        run_load(16'h0202, 2, 3, 92, 3, 3, "R2", 0);

        // R4 R7 R5: boundaries against slot 2 at 0x300..0x303.
        clear_all();
        set_entry(2, 16'h0300, 4, 64'h0000_0000_4433_2211, 102, 0);
        run_load(16'h02FC, 4, 1, 93, 3, 2, "R7", 0);
        run_load(16'h0304, 2, 1, 94, 3, 2, "R7", 0);
        run_load(16'h0300, 4, 1, 95, 3, 2, "R4", 0);
        run_load(16'h0302, 2, 1, 96, 3, 2, "R4", 0);
        run_load(16'h02FE, 4, 4, 97, 3, 2, "R5", 0);

        // R8: long scan with a second request raised while busy.
        clear_all();
        run_load(16'h0400, 2, 1, 98, 7, 0, "R8", 1);
        repeat (12) @(negedge clk);
        chk(exp_q.size() == 0, "R8", "no extra result", DW'(exp_q.size()), '0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL R8 watchdog actual=%0d expected=%0d", cyc, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule